// File: doc/BRIEF.md
# List Decoder Path Pointer Memory

A list decoder for polar codes keeps several candidate paths alive at once, and each path needs intermediate likelihoods for every stage of the decoding graph. Copying whole likelihood arrays when a path is duplicated costs too much. This block stores a small table instead. For every path and every intermediate stage, the table records which likelihood memory holds that path's values for that stage. The decoder cores read this table to steer their likelihood multiplexers. When a path writes a stage, it claims ownership of that stage. When path selection picks the surviving parents, the whole table is rearranged in one clock.

The table has `NUM_PATHS` rows. Each row has `LOG_N - 1` entries, one for each stored stage from 1 to `LOG_N - 1`. Each entry is `ceil(log2 NUM_PATHS)` bits wide. Stage `LOG_N` is the channel memory, which all paths share. Stage 0 is the decision stage and is never stored. The block also returns the first stage to be read for the current bit index. The control sequencer uses it to run the stage updates downward from that point.

Top module: `list_ptr_mem`

## Requirements
- R1: After reset, and one cycle after `clear` is high, every entry is 0. `clear` overrides every other control input.
- R2: Field l of `rd_sel` (bits `l*PW +: PW`) equals entry (l, `rd_stage`) when `rd_stage` is between 1 and `LOG_N-1`. For any other `rd_stage` value, including 0 and the channel stage `LOG_N`, every field is 0.
- R3: With `wr_en` high and `wr_stage` between 1 and `LOG_N-1`, entry (l, `wr_stage`) becomes l for every path l on the next cycle. All other entries keep their values. A `wr_stage` of 0 or of `LOG_N` or more changes nothing.
- R4: On a copy, every row l is replaced in the same cycle by the former contents of row `parent[l*PW +: PW]`, across all stages. All rows are read before any row is written, so a parent row that is itself overwritten in that cycle is still copied as it was.
- R5: A copy takes place when `sel_req` is high and either `frozen` is low or `bit_idx` is all ones (the last bit). When `sel_req` is high, `frozen` is high and `bit_idx` is not the last bit, nothing changes.
- R6: A copy takes precedence over a write in the same cycle, and that write is dropped.
- R7: `top_stage` is `LOG_N` when `bit_idx` is 0. Otherwise it is one plus the position of the lowest set bit of `bit_idx`.
- R8: When `clear`, `wr_en` and `sel_req` are all low, the entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Codeword start: zero all entries |
| bit_idx | input | LOG_N | Zero-based index of the bit being decoded |
| top_stage | output | $clog2(LOG_N+1) | First stage read for this bit |
| rd_stage | input | $clog2(LOG_N+1) | Stage whose owner is requested |
| rd_sel | output | NUM_PATHS*PW | Per-path memory select for `rd_stage` |
| wr_en | input | 1 | All paths wrote stage `wr_stage` |
| wr_stage | input | $clog2(LOG_N+1) | Stage just written |
| sel_req | input | 1 | Path selection result is valid |
| frozen | input | 1 | Current bit is frozen |
| parent | input | NUM_PATHS*PW | Surviving parent index per path |

## Verification
The bench builds the block with four paths and `LOG_N = 4`. With these values every stored stage is read out on each check, and the last-bit exception for frozen bits is reachable with a small `bit_idx`. Four paths allow parent vectors that swap, fan out and drop rows all at once. These expose any copy that reads a row after it has been overwritten. Every `top_stage` value for the sixteen bit indices is also covered.

// File: rtl/list_ptr_mem.sv
module list_ptr_mem #(
  parameter int NUM_PATHS = 4,
  parameter int LOG_N     = 10
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         clear,
  input  logic [LOG_N-1:0]                             bit_idx,
  output logic [$clog2(LOG_N+1)-1:0]                   top_stage,
  input  logic [$clog2(LOG_N+1)-1:0]                   rd_stage,
  output logic [NUM_PATHS*((NUM_PATHS>1)?$clog2(NUM_PATHS):1)-1:0] rd_sel,
  input  logic                                         wr_en,
  input  logic [$clog2(LOG_N+1)-1:0]                   wr_stage,
  input  logic                                         sel_req,
  input  logic                                         frozen,
  input  logic [NUM_PATHS*((NUM_PATHS>1)?$clog2(NUM_PATHS):1)-1:0] parent
);
  localparam int PW  = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1;
  localparam int SW  = $clog2(LOG_N + 1);
  localparam int NST = LOG_N - 1;
  localparam int IW  = (NST > 1) ? $clog2(NST) : 1;

  function automatic logic [NUM_PATHS*PW-1:0] self_vec();
    logic [NUM_PATHS*PW-1:0] v;
    for (int l = 0; l < NUM_PATHS; l++) v[l*PW +: PW] = PW'(l);
    return v;
  endfunction
  localparam logic [NUM_PATHS*PW-1:0] SELF = self_vec();

  logic [PW-1:0] ptr [NUM_PATHS][NST];
  logic [IW-1:0] wr_idx, rd_idx;
  logic          wr_ok, rd_ok, last_bit, copy_go;
  logic [SW-1:0] ts;

  assign last_bit = &bit_idx;
  assign copy_go  = sel_req & (~frozen | last_bit);
  assign wr_ok    = (wr_stage != '0) && (int'(wr_stage) < LOG_N);
  assign rd_ok    = (rd_stage != '0) && (int'(rd_stage) < LOG_N);
  assign wr_idx   = wr_ok ? IW'(wr_stage - 1'b1) : '0;
  assign rd_idx   = rd_ok ? IW'(rd_stage - 1'b1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_PATHS; l++)
        for (int k = 0; k < NST; k++) ptr[l][k] <= '0;
    end else if (clear) begin
      for (int l = 0; l < NUM_PATHS; l++)
        for (int k = 0; k < NST; k++) ptr[l][k] <= '0;
    end else if (copy_go) begin
      for (int l = 0; l < NUM_PATHS; l++)
        for (int k = 0; k < NST; k++)
          ptr[l][k] <= ptr[parent[l*PW +: PW]][k];
    end else if (wr_en && wr_ok) begin
      for (int l = 0; l < NUM_PATHS; l++) ptr[l][wr_idx] <= PW'(l);
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_PATHS; l++)
      rd_sel[l*PW +: PW] = rd_ok ? ptr[l][rd_idx] : '0;
  end

  always_comb begin
    ts = SW'(LOG_N);
    for (int k = LOG_N - 1; k >= 0; k--)
      if (bit_idx[k]) ts = SW'(k + 1);
  end
  assign top_stage = ts;

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> rd_sel == '0);

  p_write_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ok && !clear && !copy_go)
      |=> (rd_stage != $past(wr_stage) || rd_sel == SELF));

  p_identity_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_go && !clear && parent == SELF)
      |=> (!$stable(rd_stage) || $stable(rd_sel)));

  p_frozen_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && frozen && !(&bit_idx) && !clear && !wr_en)
      |=> (!$stable(rd_stage) || $stable(rd_sel)));

  p_top_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (top_stage >= SW'(1) && top_stage <= SW'(LOG_N)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !wr_en && !sel_req)
      |=> (!$stable(rd_stage) || $stable(rd_sel)));
endmodule

// File: tb/list_ptr_mem_test.sv
`timescale 1ns/1ps
module list_ptr_mem_test;
  localparam int L  = 4;
  localparam int LN = 4;
  localparam int PW = 2;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0, clear = 0, wr_en = 0, sel_req = 0, frozen = 0;
  logic [LN-1:0] bit_idx = '0;
  logic [SW-1:0] top_stage, rd_stage = '0, wr_stage = '0;
  logic [L*PW-1:0] rd_sel, parent = '0;

  int mdl [L][LN];
  int errors = 0, checks = 0;
  bit done = 0;

  list_ptr_mem #(.NUM_PATHS(L), .LOG_N(LN)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bit_idx(bit_idx),
    .top_stage(top_stage), .rd_stage(rd_stage), .rd_sel(rd_sel),
    .wr_en(wr_en), .wr_stage(wr_stage), .sel_req(sel_req),
    .frozen(frozen), .parent(parent));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rows(input string req);
    for (int s = 0; s <= LN; s++) begin
      rd_stage = SW'(s);
      #1;
      for (int l = 0; l < L; l++)
        check(req, int'(rd_sel[l*PW +: PW]),
              (s >= 1 && s < LN) ? mdl[l][s] : 0);
    end
  endtask

  task automatic cycle(input bit c, input bit we, input int ws, input bit sr,
                       input bit fz, input int bi, input logic [L*PW-1:0] par);
    int old [L][LN];
    bit cp;
    clear = c; wr_en = we; wr_stage = SW'(ws); sel_req = sr; frozen = fz;
    bit_idx = LN'(bi); parent = par;
    @(posedge clk); #2;
    clear = 0; wr_en = 0; sel_req = 0; frozen = 0;
    old = mdl;
    cp = sr && (!fz || bi == (1 << LN) - 1);
    if (c) begin
      for (int l = 0; l < L; l++) for (int k = 0; k < LN; k++) mdl[l][k] = 0;
    end else if (cp) begin
      for (int l = 0; l < L; l++)
        for (int k = 0; k < LN; k++) mdl[l][k] = old[int'(par[l*PW +: PW])][k];
    end else if (we && ws >= 1 && ws < LN) begin
      for (int l = 0; l < L; l++) mdl[l][ws] = l;
    end
  endtask

  function automatic logic [L*PW-1:0] rnd_par();
    logic [L*PW-1:0] v;
    for (int l = 0; l < L; l++) v[l*PW +: PW] = PW'($urandom_range(0, L-1));
    return v;
  endfunction

  task automatic t_reset();
    check_rows("R1 reset zero, R2 read range");
  endtask

  task automatic t_write();
    cycle(0, 1, 2, 0, 0, 0, '0); check_rows("R3 write stage 2");
    cycle(0, 1, 0, 0, 0, 0, '0); check_rows("R3 stage 0 ignored");
    cycle(0, 1, LN, 0, 0, 0, '0); check_rows("R3 channel stage ignored");
    cycle(0, 1, 1, 0, 0, 0, '0); check_rows("R3 write stage 1");
  endtask

  task automatic t_copy();
    cycle(0, 0, 0, 1, 0, 3, {2'd0, 2'd0, 2'd0, 2'd1}); check_rows("R4 fan-out copy");
    cycle(0, 1, 3, 0, 0, 0, '0); check_rows("R3 write stage 3");
    cycle(0, 0, 0, 1, 0, 5, {2'd0, 2'd1, 2'd2, 2'd3}); check_rows("R4 reversed copy");
    for (int n = 0; n < 40; n++) begin
      cycle(0, 1, $urandom_range(0, LN), 0, 0, 0, '0);
      cycle(0, 0, 0, 1, 0, 2, rnd_par());
      check_rows("R4 random parents");
    end
  endtask

  task automatic t_frozen();
    cycle(0, 1, 2, 0, 0, 0, '0);
    cycle(0, 0, 0, 1, 0, 1, {2'd3, 2'd3, 2'd2, 2'd2});
    check_rows("R5 setup");
    cycle(0, 0, 0, 1, 1, 6, {2'd0, 2'd0, 2'd0, 2'd0}); check_rows("R5 frozen not last skipped");
    cycle(0, 0, 0, 1, 1, 15, {2'd1, 2'd0, 2'd3, 2'd2}); check_rows("R5 frozen last bit copies");
  endtask

  task automatic t_priority();
    cycle(0, 1, 1, 1, 0, 4, {2'd2, 2'd2, 2'd2, 2'd2}); check_rows("R6 copy beats write");
    cycle(1, 1, 2, 1, 0, 4, {2'd1, 2'd1, 2'd1, 2'd1}); check_rows("R1 clear beats all");
  endtask

  task automatic t_hold();
    cycle(0, 1, 3, 0, 0, 0, '0);
    cycle(0, 0, 0, 1, 0, 7, {2'd1, 2'd2, 2'd3, 2'd0});
    for (int n = 0; n < 3; n++) cycle(0, 0, 2, 0, 1, 9, rnd_par());
    check_rows("R8 hold when idle");
  endtask

  task automatic t_top();
    for (int b = 0; b < (1 << LN); b++) begin
      int exp;
      bit_idx = LN'(b);
      #1;
      exp = LN;
      if (b != 0) begin
        exp = 1;
        while (((b >> (exp - 1)) & 1) == 0) exp++;
      end
      check("R7 top stage", int'(top_stage), exp);
    end
  endtask

  initial begin
    for (int l = 0; l < L; l++) for (int k = 0; k < LN; k++) mdl[l][k] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_write();
    t_copy();
    t_frozen();
    t_priority();
    t_hold();
    t_top();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule